// File: doc/BRIEF.md
# Flash Write Unlock Sequencer

This block decides whether software may start a self-programming operation on on-chip non-volatile memory. It sits on a simple register bus and watches two registers: a key register and a control register. The control register holds a write-enable bit, a two-bit operation code and a start bit. The start bit is only accepted when three bus steps land on three back-to-back clock cycles. The first step writes 55h to the key register, the second writes AAh to it, and the third writes the control register with both the start bit and the write-enable bit set. The write-enable bit must also already be stored when the first key arrives.

When the sequence is accepted, the block sends a one-clock start pulse and the operation code to the memory controller. It then holds the CPU until the controller reports completion on its done input. Any break in the sequence cancels it. A break is an idle bus cycle, a read, a write to another address, a wrong key value, or an interrupt/halt event. If software sets the start bit without a valid unlock, the start bit stays clear and a sticky error flag is raised. The operation codes cover row erase, committing write latches to program memory, committing latches to the user ID area, and writing configuration words.

Top module: `flash_unlock_seq`

## Requirements
- R1: After reset, `mem_go`, `cpu_hold` and `unlock_err` are 0, the sequencer is idle, and the control register reads 00h.
- R2: The control register sits at address 0. Its fields are: bit 0 = start, which reads 1 while an operation is in progress; bit 1 = write-enable; bits 3:2 = operation code (00 row erase, 01 program-latch commit, 10 user-ID commit, 11 configuration write); bit 7 = error. A control write that does not launch an operation and arrives while idle loads bits 1 and 3:2 from the write data.
- R3: The key register sits at address 1 and always reads 00h. Any address other than 0 reads 00h.
- R4: A launch occurs on this sequence: a key write of 55h while the stored write-enable bit is 1, then a key write of AAh on the next cycle, then a control write with bits 0 and 1 both set on the cycle after that. On a launch, `mem_go` is 1 for exactly the one cycle after that edge, and `mem_op` carries bits 3:2 of that write.
- R5: Any cycle between steps that is not the expected step cancels the sequence. This covers an idle bus cycle, a read, a write to another address, and a key write of the wrong value.
- R6: `brk_evt` high in a cycle cancels any sequence in progress, including the cycle of the start-bit write.
- R7: No launch occurs if write-enable was clear when 55h was written, or if the start-bit write carries bit 1 = 0.
- R8: A control write with bit 0 = 1 that does not launch (while idle) leaves the start bit 0 and sets the sticky error flag. Writing 1 to bit 7 clears the flag. If both happen in the same write, the set wins.
- R9: `cpu_hold` is 1 from the launch until `mem_done` pulses. It drops combinationally in the cycle `mem_done` is high, and the start bit reads 0 after that edge.
- R10: While an operation is in progress, bus writes have no effect. `mem_done` outside an operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| brk_evt | input | 1 | Interrupt or debug halt occurred this cycle |
| mem_done | input | 1 | Memory operation finished (one-cycle pulse) |
| mem_go | output | 1 | One-cycle start pulse to the memory controller |
| mem_op | output | 2 | Operation code for the memory controller |
| cpu_hold | output | 1 | CPU stall while the operation runs |
| unlock_err | output | 1 | Sticky error flag for an unlocked start attempt |

## Verification
The bench breaks the sequence in each way it can break. It inserts an idle cycle, a read of the key register, a wrong second key and a halt event between steps. It also tries the sequence with write-enable cleared beforehand and with write-enable missing from the start write. A sequencer that tolerated gaps or treated reads as neutral would launch in those cases. A sequencer that latched write-enable too late would launch in the cleared case. The bench also drives key and control writes during a running operation. A block that did not gate the bus there would change the operation code or rearm the sequence. In the cycle of the done pulse, the bench checks that the hold has already dropped while the start bit still reads 1. Finally, it checks that a single write which both sets and clears the error leaves the error set.

// File: rtl/flash_unlock_pkg.sv
package flash_unlock_pkg;
  localparam int REG_W   = 8;
  localparam int OP_W    = 2;
  localparam int GO_BIT  = 0;
  localparam int WEN_BIT = 1;
  localparam int OP_LSB  = 2;
  localparam int ERR_BIT = REG_W - 1;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [OP_W-1:0]  op_t;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FIRST = 2'd1,
    SEQ_ARMED = 2'd2
  } seq_t;

  function automatic reg_t ctl_image(logic err, op_t op, logic wen, logic go);
    reg_t img;
    img = '0;
    img[ERR_BIT] = err;
    img[OP_LSB +: OP_W] = op;
    img[WEN_BIT] = wen;
    img[GO_BIT] = go;
    return img;
  endfunction

  function automatic logic start_req(reg_t d);
    return d[GO_BIT] && d[WEN_BIT];
  endfunction

  function automatic op_t op_field(reg_t d);
    return d[OP_LSB +: OP_W];
  endfunction
endpackage

// File: rtl/flash_unlock_keyseq.sv
module flash_unlock_keyseq
  import flash_unlock_pkg::*;
#(
  parameter reg_t KEY_FIRST  = 8'h55,
  parameter reg_t KEY_SECOND = 8'hAA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_wr,
  input  logic ctl_wr,
  input  reg_t wdata,
  input  logic wen_stored,
  input  logic brk,
  input  logic busy,
  output logic armed,
  output logic launch
);
  seq_t st, st_nxt;

  always_comb begin
    st_nxt = SEQ_IDLE;
    launch = 1'b0;
    if (!brk && !busy) begin
      unique case (st)
        SEQ_IDLE:  if (key_wr && wdata == KEY_FIRST && wen_stored) st_nxt = SEQ_FIRST;
        SEQ_FIRST: if (key_wr && wdata == KEY_SECOND) st_nxt = SEQ_ARMED;
        SEQ_ARMED: launch = ctl_wr && start_req(wdata);
        default:   st_nxt = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SEQ_IDLE;
    else        st <= st_nxt;
  end

  assign armed = (st == SEQ_ARMED);
endmodule

// File: rtl/flash_unlock_ctlreg.sv
module flash_unlock_ctlreg
  import flash_unlock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_upd,
  input  logic wen_in,
  input  op_t  op_in,
  input  logic err_clr,
  input  logic go_fail,
  input  logic busy,
  input  logic sel_ctl,
  output logic wen,
  output op_t  op,
  output logic err,
  output reg_t rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0;
      op  <= '0;
    end else if (ctl_upd) begin
      wen <= wen_in;
      op  <= op_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (go_fail) err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  assign rdata = sel_ctl ? ctl_image(err, op, wen, busy) : '0;
endmodule

// File: rtl/flash_unlock_optrack.sv
module flash_unlock_optrack (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  output logic busy,
  output logic go_pulse,
  output logic hold
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      go_pulse <= 1'b0;
    end else begin
      go_pulse <= launch;
      if (launch)             busy <= 1'b1;
      else if (busy && done)  busy <= 1'b0;
    end
  end

  assign hold = busy && !done;
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq
  import flash_unlock_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR   = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'(1),
  parameter reg_t              KEY_FIRST  = 8'h55,
  parameter reg_t              KEY_SECOND = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              brk_evt,
  input  logic              mem_done,
  output logic              mem_go,
  output logic [OP_W-1:0]   mem_op,
  output logic              cpu_hold,
  output logic              unlock_err
);
  logic key_wr, ctl_wr, ctl_upd, go_fail;
  logic seq_armed, seq_launch, op_busy;
  logic wen_q;

  assign key_wr  = bus_en && bus_we && (bus_addr == KEY_ADDR);
  assign ctl_wr  = bus_en && bus_we && (bus_addr == CTL_ADDR);
  assign ctl_upd = ctl_wr && !op_busy;
  assign go_fail = ctl_upd && bus_wdata[GO_BIT] && !seq_launch;

  flash_unlock_keyseq #(
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_keyseq (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr    (key_wr),
    .ctl_wr    (ctl_wr),
    .wdata     (bus_wdata),
    .wen_stored(wen_q),
    .brk       (brk_evt),
    .busy      (op_busy),
    .armed     (seq_armed),
    .launch    (seq_launch)
  );

  flash_unlock_ctlreg u_ctlreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_upd(ctl_upd),
    .wen_in (bus_wdata[WEN_BIT]),
    .op_in  (op_field(bus_wdata)),
    .err_clr(ctl_upd && bus_wdata[ERR_BIT]),
    .go_fail(go_fail),
    .busy   (op_busy),
    .sel_ctl(bus_addr == CTL_ADDR),
    .wen    (wen_q),
    .op     (mem_op),
    .err    (unlock_err),
    .rdata  (bus_rdata)
  );

  flash_unlock_optrack u_optrack (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (seq_launch),
    .done    (mem_done),
    .busy    (op_busy),
    .go_pulse(mem_go),
    .hold    (cpu_hold)
  );
endmodule

// File: rtl/flash_unlock_seq_chk.sv
module flash_unlock_seq_chk
  import flash_unlock_pkg::*;
#(
  parameter int                ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR   = ADDR_W'(0),
  parameter logic [ADDR_W-1:0] KEY_ADDR   = ADDR_W'(1),
  parameter reg_t              KEY_SECOND = 8'hAA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              brk_evt,
  input logic              mem_done,
  input logic              mem_go,
  input logic [OP_W-1:0]   mem_op,
  input logic              unlock_err,
  input logic              seq_armed,
  input logic              seq_launch,
  input logic              op_busy
);
  assert_go_one_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_go |=> !mem_go);

  assert_go_follows_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_launch |=> (mem_go && op_busy));

  assert_armed_after_second_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_armed) |-> $past(bus_en && bus_we && bus_addr == KEY_ADDR && bus_wdata == KEY_SECOND));

  assert_break_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> (!seq_armed && !mem_go));

  assert_key_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == KEY_ADDR) |-> (bus_rdata == '0));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_err) |-> $past(bus_en && bus_we && bus_addr == CTL_ADDR && bus_wdata[GO_BIT]));

  assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !mem_done) |=> op_busy);

  assert_done_ends_op_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && mem_done) |=> !op_busy);

  assert_op_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && $past(op_busy)) |-> $stable(mem_op));
endmodule

bind flash_unlock_seq flash_unlock_seq_chk #(
  .ADDR_W    (ADDR_W),
  .CTL_ADDR  (CTL_ADDR),
  .KEY_ADDR  (KEY_ADDR),
  .KEY_SECOND(KEY_SECOND)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .brk_evt   (brk_evt),
  .mem_done  (mem_done),
  .mem_go    (mem_go),
  .mem_op    (mem_op),
  .unlock_err(unlock_err),
  .seq_armed (seq_armed),
  .seq_launch(seq_launch),
  .op_busy   (op_busy)
);

// File: tb/flash_unlock_seq_bench.sv
`timescale 1ns/1ps
module flash_unlock_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       brk_evt = 1'b0, mem_done = 1'b0;
  logic       mem_go, cpu_hold, unlock_err;
  logic [1:0] mem_op;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  flash_unlock_seq u_flash_unlock_seq (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .brk_evt(brk_evt), .mem_done(mem_done), .mem_go(mem_go),
    .mem_op(mem_op), .cpu_hold(cpu_hold), .unlock_err(unlock_err)
  );

  // vector: en we addr wdata brk done | go hold err rdata op | req
  function automatic logic [32:0] vt(logic en, logic we, logic [3:0] a, logic [7:0] d,
      logic brk, logic dn, logic eg, logic eh, logic ee, logic [7:0] erd,
      logic [1:0] eop, logic [3:0] rq);
    return {en, we, a, d, brk, dn, eg, eh, ee, erd, eop, rq};
  endfunction

  localparam int NV = 46;
  localparam logic [32:0] VEC [NV] = '{
    vt(1,1,0,8'h02,0,0, 0,0,0,8'h02,0, 2),  // R2 set write-enable
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,0, 3),  // R3 key reads zero
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,0, 3),
    vt(1,1,0,8'h07,0,0, 1,1,0,8'h07,1, 4),  // R4 launch, op 01
    vt(0,0,0,8'h00,0,0, 0,1,0,8'h07,1, 4),  // R4 pulse one wide
    vt(1,1,1,8'h55,0,0, 0,1,0,8'h00,1,10),  // R10 key write while busy
    vt(1,1,0,8'h80,0,0, 0,1,0,8'h07,1,10),  // R10 ctl write while busy
    vt(0,0,0,8'h00,0,1, 0,0,0,8'h06,1, 9),  // R9 done ends op
    vt(0,0,0,8'h00,0,0, 0,0,0,8'h06,1, 9),
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,1, 5),  // R5 idle gap
    vt(0,0,0,8'h00,0,0, 0,0,0,8'h06,1, 5),
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,1, 5),
    vt(1,1,0,8'h03,0,0, 0,0,1,8'h82,0, 5),
    vt(1,1,0,8'h82,0,0, 0,0,0,8'h02,0, 8),  // R8 clear error
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,0, 5),  // R5 wrong second key
    vt(1,1,1,8'hAB,0,0, 0,0,0,8'h00,0, 5),
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,0, 5),
    vt(1,1,0,8'h0B,0,0, 0,0,1,8'h8A,2, 5),
    vt(1,1,0,8'h8A,0,0, 0,0,0,8'h0A,2, 8),
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,2, 6),  // R6 halt on second key
    vt(1,1,1,8'hAA,1,0, 0,0,0,8'h00,2, 6),
    vt(1,1,0,8'h0F,0,0, 0,0,1,8'h8E,3, 6),
    vt(1,1,0,8'h8E,0,0, 0,0,0,8'h0E,3, 8),
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,3, 6),  // R6 halt on start write
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,3, 6),
    vt(1,1,0,8'h03,1,0, 0,0,1,8'h82,0, 6),
    vt(1,1,0,8'h80,0,0, 0,0,0,8'h00,0, 7),  // R7 clear wen
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,0, 7),
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,0, 7),
    vt(1,1,0,8'h03,0,0, 0,0,1,8'h82,0, 7),
    vt(1,1,0,8'h82,0,0, 0,0,0,8'h02,0, 8),
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,0, 7),  // R7 start write lacks wen
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,0, 7),
    vt(1,1,0,8'h01,0,0, 0,0,1,8'h80,0, 7),
    vt(1,1,0,8'h82,0,0, 0,0,0,8'h02,0, 8),
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,0, 5),  // R5 read between steps
    vt(1,0,1,8'h00,0,0, 0,0,0,8'h00,0, 5),
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,0, 5),
    vt(1,1,0,8'h03,0,0, 0,0,1,8'h82,0, 5),
    vt(1,1,0,8'h83,0,0, 0,0,1,8'h82,0, 8),  // R8 set wins over clear
    vt(1,1,0,8'h82,0,0, 0,0,0,8'h02,0, 8),
    vt(1,1,1,8'h55,0,0, 0,0,0,8'h00,0, 4),  // R4 config write op 11
    vt(1,1,1,8'hAA,0,0, 0,0,0,8'h00,0, 4),
    vt(1,1,0,8'h0F,0,0, 1,1,0,8'h0F,3, 4),
    vt(0,0,0,8'h00,0,1, 0,0,0,8'h0E,3, 9),
    vt(0,0,0,8'h00,0,1, 0,0,0,8'h0E,3,10)   // R10 stray done ignored
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic en, logic we, logic [3:0] a, logic [7:0] d, logic brk, logic dn);
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d; brk_evt = brk; mem_done = dn;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_en = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; brk_evt = 0; mem_done = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 go", mem_go, 0);
    check("R1 hold", cpu_hold, 0);
    check("R1 err", unlock_err, 0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      string t;
      v = VEC[i];
      drive(v[32], v[31], v[30:27], v[26:19], v[18], v[17]);
      @(posedge clk); #1;
      t = $sformatf("R%0d vec%0d", v[3:0], i);
      check({t, " go"},    mem_go,     v[16]);
      check({t, " hold"},  cpu_hold,   v[15]);
      check({t, " err"},   unlock_err, v[14]);
      check({t, " rdata"}, bus_rdata,  v[13:6]);
      if (v[16]) check({t, " op"}, mem_op, v[5:4]);
    end

    // R9: hold drops in the done cycle while the start bit still reads 1
    drive(1,1,1,8'h55,0,0);
    drive(1,1,1,8'hAA,0,0);
    drive(1,1,0,8'h07,0,0);
    drive(0,0,0,8'h00,0,0);
    drive(0,0,0,8'h00,0,0);
    drive(0,0,0,8'h00,0,1);
    #1;
    check("R9 hold released in done cycle", cpu_hold, 0);
    check("R9 start bit during done cycle", bus_rdata, 8'h07);
    @(posedge clk); #1;
    check("R9 start bit after done", bus_rdata, 8'h06);
    drive(0,0,0,8'h00,0,0);

    // R1: reset during an operation
    drive(1,1,1,8'h55,0,0);
    drive(1,1,1,8'hAA,0,0);
    drive(1,1,0,8'h0B,0,0);
    @(posedge clk); #1;
    check("R4 launch before reset", cpu_hold, 1);
    do_reset();
    #1;
    check("R1 hold after reset", cpu_hold, 0);
    check("R1 ctl after reset", bus_rdata, 0);
    check("R1 err after reset", unlock_err, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule